// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block sits between the processor's bus interface and the pins of an external memory area. It stretches each processor access to that area. When the core starts an access, the controller decodes the upper address bits. It works out whether the target is internal or external and, for an external target, which of the chip-select regions it falls in.

Internal targets complete with no wait cycles. An external access runs through four stages:

- A base strobe cycle.
- A per-region programmed number of wait cycles, one to four.
- Extra cycles for as long as the device holds its active-low wait line asserted once the programmed waits are spent.
- A single ready cycle back to the core.

A mode input forces every access to be internal. This is the behaviour for a device running with no external bus. The read and write strobes and the region chip-selects are all active low. They are held for the whole stretched access and drop in the ready cycle.

Top module: `bus_wait_ctrl`

## Requirements
- R1: After reset, `core_rdy` is 0, `ext_rd_n` and `ext_wr_n` are 1, and every bit of `ext_cs_n` is 1.
- R2: An access starts in a cycle where `cpu_rd` or `cpu_wr` is 1 and the controller is idle. An access whose `addr_hi[3:2]` is not 2'b01 is internal. For an internal access, `core_rdy` is 1 in the cycle after the start, and no strobe or chip-select is asserted.
- R3: While `single_chip` is 1, every access is internal, whatever its address.
- R4: An external access (`addr_hi[3:2]` = 2'b01 with `single_chip` = 0) targets region `addr_hi[1:0]`. While its strobe is low, `ext_cs_n` is low in exactly that bit position and high in all others.
- R5: The wait field for region r is `wait_cfg[2r+1:2r]`. A field value f gives f+1 wait cycles. With the wait line released, the strobe is low for f+2 consecutive cycles, starting in the cycle after the start.
- R6: The wait line is sampled in the last programmed wait cycle and in every cycle after it. Each sampled cycle with `ext_wait_n` = 0 adds one strobe cycle. The access ends after the first sampled cycle with `ext_wait_n` = 1.
- R7: `ext_wait_n` = 0 during the base cycle and the earlier programmed wait cycles has no effect on the access length.
- R8: `core_rdy` is 1 for exactly one cycle per access. In that cycle, both strobes and all chip-selects are high.
- R9: A start with only `cpu_rd` = 1 drives `ext_rd_n` low. A start with `cpu_wr` = 1 (alone or together with `cpu_rd`) drives `ext_wr_n` low. The two strobes are never low together.
- R10: A start request made while an access is in progress is ignored. It does not alter that access, and it does not begin another one afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| single_chip | input | 1 | 1 = treat every access as internal |
| wait_cfg | input | 8 | Four 2-bit wait fields, region r at bits [2r+1:2r] |
| addr_hi | input | 4 | Byte address bits 23..20: [3:2] area tag, [1:0] region |
| cpu_rd | input | 1 | Read start request |
| cpu_wr | input | 1 | Write start request (takes priority over read) |
| ext_wait_n | input | 1 | Active-low wait from the external device |
| core_rdy | output | 1 | One-cycle access completion to the core |
| ext_rd_n | output | 1 | Active-low external read strobe |
| ext_wr_n | output | 1 | Active-low external write strobe |
| ext_cs_n | output | 4 | Active-low per-region chip-selects |

## Verification
The hardest case to set up from the ports is the boundary between the programmed waits and the sampled wait window. An asserted wait line must be ignored up to the last programmed wait cycle and then honoured from that cycle on.

The bench holds `ext_wait_n` low for exactly waits+extra cycles, counted from the first strobe cycle. With extra = 0, the line is low across every programmed wait cycle except the one where sampling begins. The access length must not move. With extra > 0, each further low cycle must add exactly one strobe cycle.

Requests made during the first strobe cycle aim at a different region. They test that a busy controller ignores them.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

  localparam int CNT_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STRB = 2'd1,
    ST_DONE = 2'd2
  } bwc_state_e;

  // A 2-bit region field encodes 1..4 wait cycles.
  function automatic logic [CNT_W-1:0] waits_of_field(input logic [1:0] fld);
    return {1'b0, fld} + 3'd1;
  endfunction

endpackage

// File: rtl/bwc_region_dec.sv
module bwc_region_dec #(
  parameter int HI_W    = 4,
  parameter int RGN_W   = 2,
  parameter int EXT_TAG = 1
) (
  input  logic [HI_W-1:0]          addr_hi,
  input  logic                     single_chip,
  input  logic [2*(1<<RGN_W)-1:0]  wait_cfg,
  output logic                     is_ext,
  output logic [RGN_W-1:0]         rgn_idx,
  output logic [bwc_pkg::CNT_W-1:0] wait_cnt
);
  import bwc_pkg::*;

  localparam int TAG_W = HI_W - RGN_W;

  logic [TAG_W-1:0] area_tag;
  logic [1:0]       fld;

  assign area_tag = addr_hi[HI_W-1:RGN_W];
  assign rgn_idx  = addr_hi[RGN_W-1:0];
  assign is_ext   = !single_chip && (area_tag == TAG_W'(EXT_TAG));
  assign fld      = wait_cfg[{rgn_idx, 1'b0} +: 2];
  assign wait_cnt = waits_of_field(fld);

endmodule

// File: rtl/bwc_wait_seq.sv
module bwc_wait_seq (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      is_ext,
  input  logic [bwc_pkg::CNT_W-1:0] wait_cnt,
  input  logic                      ext_wait_n,
  output logic                      accept,
  output logic                      strobe_on,
  output logic                      rdy_pulse
);
  import bwc_pkg::*;

  bwc_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             in_sample;

  assign accept    = start && (state == ST_IDLE);
  assign strobe_on = (state == ST_STRB);
  assign rdy_pulse = (state == ST_DONE);
  assign in_sample = strobe_on && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          if (is_ext) begin
            state <= ST_STRB;
            cnt   <= wait_cnt;
          end else begin
            state <= ST_DONE;
          end
        end
        ST_STRB: begin
          if (cnt != '0)      cnt   <= cnt - 3'd1;
          else if (ext_wait_n) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 3'd4) else $error("cnt out of range"); // R5
  AST_WAIT_EXTENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sample && !ext_wait_n) |=> strobe_on) else $error("wait not honoured"); // R6
  AST_WAIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sample && ext_wait_n) |=> rdy_pulse) else $error("no end after release"); // R6
  AST_EARLY_WAIT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_on && !in_sample) |=> strobe_on) else $error("early end"); // R7
  AST_INT_ZERO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_ext) |=> rdy_pulse) else $error("internal not zero-wait"); // R2
  AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_pulse |=> !rdy_pulse) else $error("ready longer than one cycle"); // R8

endmodule

// File: rtl/bwc_strobe_drv.sv
module bwc_strobe_drv #(
  parameter int RGN_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept,
  input  logic                  start_wr,
  input  logic [RGN_W-1:0]      rgn_idx,
  input  logic                  strobe_on,
  output logic                  ext_rd_n,
  output logic                  ext_wr_n,
  output logic [(1<<RGN_W)-1:0] ext_cs_n
);
  localparam int NREG = 1 << RGN_W;

  logic             wr_q;
  logic [RGN_W-1:0] rgn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b0;
      rgn_q <= '0;
    end else if (accept) begin
      wr_q  <= start_wr;
      rgn_q <= rgn_idx;
    end
  end

  assign ext_rd_n = !(strobe_on && !wr_q);
  assign ext_wr_n = !(strobe_on && wr_q);

  for (genvar r = 0; r < NREG; r++) begin : g_cs
    assign ext_cs_n[r] = !(strobe_on && (rgn_q == RGN_W'(r)));
  end

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n)) else $error("both strobes low"); // R9
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ext_cs_n)) else $error("more than one select"); // R4
  AST_STROBE_HAS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n || !ext_wr_n) |-> ($countones(~ext_cs_n) == 1)) else $error("strobe without select"); // R4
  AST_CS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_on && $past(strobe_on)) |-> $stable(ext_cs_n)) else $error("select moved mid-access"); // R10

endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl #(
  parameter int ADDR_W  = 24,
  parameter int EXT_AW  = 22,
  parameter int RGN_W   = 2,
  parameter int EXT_TAG = 1,
  localparam int NREG   = 1 << RGN_W,
  localparam int HI_W   = ADDR_W - (EXT_AW - RGN_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              single_chip,
  input  logic [2*NREG-1:0] wait_cfg,
  input  logic [HI_W-1:0]   addr_hi,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic              ext_wait_n,
  output logic              core_rdy,
  output logic              ext_rd_n,
  output logic              ext_wr_n,
  output logic [NREG-1:0]   ext_cs_n
);
  import bwc_pkg::*;

  logic             start;
  logic             is_ext;
  logic [RGN_W-1:0] rgn_idx;
  logic [CNT_W-1:0] wait_cnt;
  logic             accept;
  logic             strobe_on;

  assign start = cpu_rd || cpu_wr;

  bwc_region_dec #(.HI_W(HI_W), .RGN_W(RGN_W), .EXT_TAG(EXT_TAG)) u_dec (
    .addr_hi(addr_hi), .single_chip(single_chip), .wait_cfg(wait_cfg),
    .is_ext(is_ext), .rgn_idx(rgn_idx), .wait_cnt(wait_cnt)
  );

  bwc_wait_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .is_ext(is_ext),
    .wait_cnt(wait_cnt), .ext_wait_n(ext_wait_n),
    .accept(accept), .strobe_on(strobe_on), .rdy_pulse(core_rdy)
  );

  bwc_strobe_drv #(.RGN_W(RGN_W)) u_drv (
    .clk(clk), .rst_n(rst_n), .accept(accept), .start_wr(cpu_wr),
    .rgn_idx(rgn_idx), .strobe_on(strobe_on),
    .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .ext_cs_n(ext_cs_n)
  );

  AST_RDY_STROBES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    core_rdy |-> (ext_rd_n && ext_wr_n && (&ext_cs_n))) else $error("strobe at ready"); // R8
  AST_SINGLE_CHIP_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
    (single_chip && accept) |=> (&ext_cs_n)) else $error("external in single-chip"); // R3

endmodule

// File: tb/sim_bus_wait_ctrl.sv
module sim_bus_wait_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       single_chip = 1'b0;
  logic [7:0] wait_cfg = '0;
  logic [3:0] addr_hi = '0;
  logic       cpu_rd = 1'b0;
  logic       cpu_wr = 1'b0;
  logic       ext_wait_n = 1'b1;
  logic       core_rdy;
  logic       ext_rd_n;
  logic       ext_wr_n;
  logic [3:0] ext_cs_n;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  bus_wait_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .single_chip(single_chip), .wait_cfg(wait_cfg),
    .addr_hi(addr_hi), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .ext_wait_n(ext_wait_n),
    .core_rdy(core_rdy), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .ext_cs_n(ext_cs_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG_LIMIT) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, WDOG_LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, expv);
    end
  endtask

  // One access; exp_waits is the programmed count, extra the sampled WAIT-low cycles.
  task automatic run_access(input logic [3:0] a, input bit rd, input bit wr,
                            input bit ext, input int rgn, input int exp_waits,
                            input int extra, input bit poke, input string req);
    int k = exp_waits + extra;
    int n_str = 0;
    bit got = 0;
    bit kind_ok = 1;
    bit cs_ok = 1;
    @(negedge clk);
    addr_hi = a; cpu_rd = rd; cpu_wr = wr; ext_wait_n = 1'b1;
    @(negedge clk);
    cpu_rd = 0; cpu_wr = 0;
    for (int idx = 0; idx < 40; idx++) begin
      cpu_rd = 0;
      if (core_rdy) begin
        got = 1;
        chk(ext_rd_n && ext_wr_n && ext_cs_n == 4'hF, "R8", {ext_rd_n, ext_wr_n, ext_cs_n}, 6'h3F);
        break;
      end
      if (!ext_rd_n || !ext_wr_n) n_str++;
      if (wr) kind_ok &= (ext_wr_n == 0 && ext_rd_n == 1);
      else    kind_ok &= (ext_rd_n == 0 && ext_wr_n == 1);
      if (ext) cs_ok &= (ext_cs_n == ~(4'b0001 << rgn));
      ext_wait_n = (idx < k) ? 1'b0 : 1'b1;
      if (poke && idx == 0) begin
        cpu_rd = 1'b1;
        addr_hi = {2'b01, 2'(rgn + 1)};
      end
      @(negedge clk);
    end
    ext_wait_n = 1'b1;
    chk(got, req, got, 1);
    chk(n_str == (ext ? exp_waits + 1 + extra : 0), req, n_str, ext ? exp_waits + 1 + extra : 0);
    if (ext) begin
      chk(kind_ok, "R9", kind_ok, 1);
      chk(cs_ok, "R4", cs_ok, 1);
    end
    @(negedge clk);
    chk(!core_rdy && ext_rd_n && ext_wr_n && ext_cs_n == 4'hF,
        poke ? "R10" : "R8", {core_rdy, ext_rd_n, ext_wr_n, ext_cs_n}, 7'h3F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!core_rdy && ext_rd_n && ext_wr_n && ext_cs_n == 4'hF, "R1",
        {core_rdy, ext_rd_n, ext_wr_n, ext_cs_n}, 7'h3F);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: internal tags, read and write
    run_access(4'b0000, 1, 0, 0, 0, 0, 0, 0, "R2");
    run_access(4'b1011, 0, 1, 0, 0, 0, 0, 0, "R2");
    run_access(4'b1111, 1, 0, 0, 0, 0, 0, 0, "R2");

    // R5/R6/R7: every region x every field x extra 0..2, read/write alternating
    for (int r = 0; r < 4; r++) begin
      for (int f = 0; f < 4; f++) begin
        for (int e = 0; e < 3; e++) begin
          logic [7:0] cfg = 8'h00;
          for (int o = 0; o < 4; o++) cfg[2*o +: 2] = 2'(3 - f);
          cfg[2*r +: 2] = 2'(f);
          wait_cfg = cfg;
          run_access({2'b01, 2'(r)}, (e % 2) == 0, (e % 2) == 1, 1, r, f + 1, e, 0,
                     e == 0 ? "R7" : "R6");
        end
      end
    end

    // R5: wait line untouched, every field in region 2
    for (int f = 0; f < 4; f++) begin
      wait_cfg = {4{2'(f)}};
      run_access(4'b0110, 1, 0, 1, 2, f + 1, 0, 0, "R5");
    end

    // R9: both requests -> write
    wait_cfg = 8'h00;
    run_access(4'b0101, 1, 1, 1, 1, 1, 0, 0, "R9");

    // R10: request during an access
    wait_cfg = 8'hFF;
    run_access(4'b0100, 0, 1, 1, 0, 4, 1, 1, "R10");
    run_access(4'b0111, 1, 0, 1, 3, 4, 0, 1, "R10");

    // R3: single-chip mode turns external addresses internal
    single_chip = 1'b1;
    for (int r = 0; r < 4; r++) run_access({2'b01, 2'(r)}, 1, 0, 0, r, 0, 0, 0, "R3");
    single_chip = 1'b0;
    run_access(4'b0111, 0, 1, 1, 3, 4, 0, 0, "R3");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule